// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave-only two-wire serial interface that runs on a fast system clock and oversamples the bus lines. It recognises start and stop conditions and answers one 7-bit device address. An address-select pin picks which of two addresses that is. Behind the interface sit two 8-bit register images, A and B, held in a modelled non-volatile store. The two images share a single pair of route-select bits in bits 7:6. The interface also keeps a snapshot of a 5-bit input port.

A master writes one data byte per register update. Bits 7:6 of that byte name the target image and at the same time become the new shared route-select pair. Bits 5:0 carry the new data. The write is held until the next stop or start condition and is then handed to the store. The store takes a parameterised number of system clocks to commit the write. During that time it raises a busy flag, and it marks the end of the commit with a one-cycle done pulse.

A read streams image A, then image B, then the port snapshot, and then wraps back to A. It continues until the master answers a byte with NACK. A write-protect pin lets writes be acknowledged on the bus without being stored.

Top module: `tws_regport`

## Requirements
- R1: A start is SDA falling while SCL is high and begins a new transfer. A stop is SDA rising while SCL is high. A stop ends any transfer, releases SDA by the next cycle, and gives a single-cycle pulse on `stop_pulse_o`.
- R2: The device acknowledges the address byte only when its upper 7 bits equal 1001110 (`addr_sel_i`=1) or 0110111 (`addr_sel_i`=0). Bit 0 of the address byte is 1 for a read. Any other address, including 0000000, gets no acknowledge and no further response.
- R3: Every write data byte is acknowledged. In a committed byte, bits 7:6 = 00 load bits 5:0 into image A, and 01 load them into image B. With 10 or 11 in bits 7:6, both data fields stay unchanged.
- R4: Bits 7:6 of both images always equal bits 7:6 of the last committed byte, whichever register that byte targeted.
- R5: A read returns image A, then image B, then the snapshot, and then A again. Each byte is sent MSB first. A NACK from the master ends the stream and releases SDA.
- R6: A master NACK after the first read byte, followed by a stop, transfers only image A. Reads never alter the images or start a commit.
- R7: The snapshot byte is 000 followed by the 5 port bits. It is captured on the first SCL rising edge after each start, so later port changes in the same transfer do not affect it.
- R8: If `wr_prot_i` is 1 when a data byte completes, the byte is acknowledged but not stored, and no commit begins.
- R9: A pending write is handed to the store at the next stop or start. `commit_busy_o` is then high for COMMIT_CYCLES cycles, and the images keep their old values during that time. The new values appear in the same cycle as the single-cycle `commit_done_o` pulse.
- R10: A write handed to the store while a commit is in progress is discarded.
- R11: After reset both images read 0x80 (route pair 10, data 0), `commit_busy_o` is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Selects which of the two device addresses is answered |
| wr_prot_i | input | 1 | 1 blocks storing of written bytes |
| port_i | input | PORT_W | Parallel input port sampled into the snapshot |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_a_o | output | 8 | Committed image A: route pair in 7:6, data in 5:0 |
| reg_b_o | output | 8 | Committed image B: route pair in 7:6, data in 5:0 |
| commit_busy_o | output | 1 | High while the store commits a write |
| commit_done_o | output | 1 | One-cycle pulse when a commit completes |
| stop_pulse_o | output | 1 | One-cycle pulse on each stop condition |

## Verification
The bench sweeps all 128 address bytes with one select level and probes the general-call address and both device addresses with the other level. A design that matches the wrong pattern, or that answers address zero, acknowledges where no acknowledge is due. It also writes to each image and checks that the other image's bits 7:6 follow. A design with separate route bits per image leaves the untouched image showing stale bits. It streams four read bytes to catch a missing wrap and changes the port in the middle of a transfer to catch a snapshot that keeps tracking the pins. It also checks that images hold steady while busy, that a second write during a commit is discarded, and that a repeated start commits a pending write. A design that commits at once, queues requests or waits only for stops fails these checks.

// File: rtl/tws_pkg.sv
package tws_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK
   } tws_state_e;

   // route pair value at reset: pass-through path
   localparam logic [1:0] ROUTE_RESET = 2'b10;
endpackage

// File: rtl/tws_line_sense.sv
module tws_line_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o,
   output logic sda_o
);
   logic scl_s, sda_s;
   logic scl_p, sda_p;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh[0] <= scl_i;
               sda_sh[0] <= sda_i;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  scl_sh[k] <= scl_sh[k-1];
                  sda_sh[k] <= sda_sh[k-1];
               end
            end
         end
         assign scl_s = scl_sh[SYNC_STAGES-1];
         assign sda_s = sda_sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise_o = scl_s & ~scl_p;
   assign scl_fall_o = ~scl_s & scl_p;
   assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
   assign sda_o      = sda_s;
endmodule

// File: rtl/tws_xfer_fsm.sv
module tws_xfer_fsm
   import tws_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR_HI = 7'b1001110,
   parameter logic [6:0] DEV_ADDR_LO = 7'b0110111,
   parameter int         PORT_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              sda_i,
   input  logic              addr_sel_i,
   input  logic              wr_prot_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [BYTE_W-1:0] reg_a_i,
   input  logic [BYTE_W-1:0] reg_b_i,
   output logic              sda_pull_o,
   output logic              wr_req_o,
   output logic [BYTE_W-1:0] wr_byte_o
);
   localparam int PAD_W = BYTE_W - PORT_W;
   localparam logic [1:0] LAST_IDX = 2'd2;

   tws_state_e        state;
   logic [2:0]        bitcnt;
   logic              got8;
   logic              acked;
   logic              rw;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   logic [1:0]        idx;
   logic              snap_arm;
   logic [PORT_W-1:0] snap;
   logic              pend;
   logic [6:0]        my_addr;
   logic [BYTE_W-1:0] snap_byte;
   logic [BYTE_W-1:0] next_tx;

   generate
      if (PAD_W > 0) begin : g_pad
         assign snap_byte = {{PAD_W{1'b0}}, snap};
      end else begin : g_nopad
         assign snap_byte = snap;
      end
   endgenerate

   assign my_addr = addr_sel_i ? DEV_ADDR_HI : DEV_ADDR_LO;

   always_comb begin
      unique case (idx)
         2'd0:    next_tx = reg_a_i;
         2'd1:    next_tx = reg_b_i;
         default: next_tx = snap_byte;
      endcase
   end

   // snapshot of the input port, first SCL rise after each start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_arm <= 1'b0;
         snap     <= '0;
      end else if (start_i) begin
         snap_arm <= 1'b1;
      end else if (scl_rise_i && snap_arm) begin
         snap_arm <= 1'b0;
         snap     <= port_i;
      end
   end

   // pending write hand-off at start or stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_req_o <= 1'b0;
      end else begin
         wr_req_o <= (start_i || stop_i) && pend;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bitcnt     <= '0;
         got8       <= 1'b0;
         acked      <= 1'b0;
         rw         <= 1'b0;
         shreg      <= '0;
         txreg      <= '0;
         idx        <= '0;
         pend       <= 1'b0;
         wr_byte_o  <= '0;
         sda_pull_o <= 1'b0;
      end else if (start_i || stop_i) begin
         state      <= start_i ? ST_ADDR : ST_IDLE;
         bitcnt     <= '0;
         got8       <= 1'b0;
         acked      <= 1'b0;
         pend       <= 1'b0;
         sda_pull_o <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_ADDR, ST_WDATA: begin
               if (scl_rise_i) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_i};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) got8 <= 1'b1;
               end else if (scl_fall_i && got8) begin
                  got8 <= 1'b0;
                  if (state == ST_ADDR) begin
                     if (shreg[7:1] == my_addr) begin
                        rw         <= shreg[0];
                        sda_pull_o <= 1'b1;
                        state      <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     sda_pull_o <= 1'b1;
                     state      <= ST_WACK;
                     if (!wr_prot_i) begin
                        pend      <= 1'b1;
                        wr_byte_o <= shreg;
                     end
                  end
               end
            end
            ST_AACK, ST_WACK: begin
               if (scl_fall_i) begin
                  bitcnt <= '0;
                  if (state == ST_AACK && rw) begin
                     idx        <= '0;
                     txreg      <= reg_a_i;
                     sda_pull_o <= ~reg_a_i[BYTE_W-1];
                     state      <= ST_RDATA;
                  end else begin
                     sda_pull_o <= 1'b0;
                     state      <= ST_WDATA;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise_i) begin
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) got8 <= 1'b1;
               end else if (scl_fall_i) begin
                  if (got8) begin
                     got8       <= 1'b0;
                     sda_pull_o <= 1'b0;
                     state      <= ST_RACK;
                  end else begin
                     txreg      <= {txreg[BYTE_W-2:0], 1'b0};
                     sda_pull_o <= ~txreg[BYTE_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise_i) begin
                  if (sda_i) begin
                     state <= ST_IDLE;
                  end else begin
                     acked <= 1'b1;
                     idx   <= (idx == LAST_IDX) ? 2'd0 : idx + 2'd1;
                  end
               end else if (scl_fall_i && acked) begin
                  acked      <= 1'b0;
                  bitcnt     <= '0;
                  txreg      <= next_tx;
                  sda_pull_o <= ~next_tx[BYTE_W-1];
                  state      <= ST_RDATA;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tws_commit_store.sv
module tws_commit_store
   import tws_pkg::*;
#(
   parameter int COMMIT_CYCLES = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req_i,
   input  logic [BYTE_W-1:0] wr_byte_i,
   output logic [BYTE_W-1:0] reg_a_o,
   output logic [BYTE_W-1:0] reg_b_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int DATA_W = BYTE_W - 2;
   localparam int CNT_W  = $clog2(COMMIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COMMIT_CYCLES - 1);

   logic [1:0]        route;
   logic [DATA_W-1:0] data_a, data_b;
   logic [BYTE_W-1:0] hold;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route  <= ROUTE_RESET;
         data_a <= '0;
         data_b <= '0;
         hold   <= '0;
         cnt    <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy_o) begin
            if (wr_req_i) begin
               hold   <= wr_byte_i;
               cnt    <= '0;
               busy_o <= 1'b1;
            end
         end else if (cnt == CNT_LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            route  <= hold[BYTE_W-1 -: 2];
            unique case (hold[BYTE_W-1 -: 2])
               2'b00:   data_a <= hold[DATA_W-1:0];
               2'b01:   data_b <= hold[DATA_W-1:0];
               default: ;
            endcase
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign reg_a_o = {route, data_a};
   assign reg_b_o = {route, data_b};
endmodule

// File: rtl/tws_regport.sv
module tws_regport
   import tws_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR_HI   = 7'b1001110,
   parameter logic [6:0] DEV_ADDR_LO   = 7'b0110111,
   parameter int         PORT_W        = 5,
   parameter int         SYNC_STAGES   = 2,
   parameter int         COMMIT_CYCLES = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_sel_i,
   input  logic              wr_prot_i,
   input  logic [PORT_W-1:0] port_i,
   output logic              sda_pull_o,
   output logic [7:0]        reg_a_o,
   output logic [7:0]        reg_b_o,
   output logic              commit_busy_o,
   output logic              commit_done_o,
   output logic              stop_pulse_o
);
   initial begin
      assert (PORT_W >= 1 && PORT_W <= BYTE_W - 3)
         else $error("PORT_W must leave three zero bits in the snapshot byte");
      assert (DEV_ADDR_HI != 7'd0 && DEV_ADDR_LO != 7'd0)
         else $error("general-call address may not be a device address");
      assert (COMMIT_CYCLES >= 1) else $error("COMMIT_CYCLES must be positive");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   logic scl_rise, scl_fall, start_det, stop_det, sda_s;
   logic wr_req;
   logic [BYTE_W-1:0] wr_byte;

   tws_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det),
      .sda_o      (sda_s)
   );

   tws_xfer_fsm #(
      .DEV_ADDR_HI (DEV_ADDR_HI),
      .DEV_ADDR_LO (DEV_ADDR_LO),
      .PORT_W      (PORT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_det),
      .stop_i     (stop_det),
      .sda_i      (sda_s),
      .addr_sel_i (addr_sel_i),
      .wr_prot_i  (wr_prot_i),
      .port_i     (port_i),
      .reg_a_i    (reg_a_o),
      .reg_b_i    (reg_b_o),
      .sda_pull_o (sda_pull_o),
      .wr_req_o   (wr_req),
      .wr_byte_o  (wr_byte)
   );

   tws_commit_store #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req_i  (wr_req),
      .wr_byte_i (wr_byte),
      .reg_a_o   (reg_a_o),
      .reg_b_o   (reg_b_o),
      .busy_o    (commit_busy_o),
      .done_o    (commit_done_o)
   );

   assign stop_pulse_o = stop_det;
endmodule

// File: rtl/tws_regport_chk.sv
module tws_regport_chk #(
   parameter int COMMIT_CYCLES = 1_000_000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_det,
   input logic       stop_pulse_o,
   input logic       sda_pull_o,
   input logic [7:0] reg_a_o,
   input logic [7:0] reg_b_o,
   input logic       commit_busy_o,
   input logic       commit_done_o
);
   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_len <= 0;
      else if (commit_busy_o) busy_len <= busy_len + 1;
      else busy_len <= 0;
   end

   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse_o |=> !sda_pull_o);

   // R1
   stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse_o |=> !stop_pulse_o);

   // R9
   commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done_o |-> (busy_len == COMMIT_CYCLES));

   // R9
   image_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_done_o |-> ($stable(reg_a_o) && $stable(reg_b_o)));

   // R9
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_busy_o) |-> $past(start_det || stop_pulse_o, 2));

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done_o |-> ($past(commit_busy_o) && !commit_busy_o));
endmodule

bind tws_regport tws_regport_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_det     (start_det),
   .stop_pulse_o  (stop_pulse_o),
   .sda_pull_o    (sda_pull_o),
   .reg_a_o       (reg_a_o),
   .reg_b_o       (reg_b_o),
   .commit_busy_o (commit_busy_o),
   .commit_done_o (commit_done_o)
);

// File: tb/tws_regport_test.sv
module tws_regport_test;
   localparam int COMMIT = 1500;
   localparam int Q      = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       addr_sel = 1'b1;
   logic       wp = 1'b0;
   logic [4:0] port = 5'h00;
   logic       sda_pull, busy, done, stop_p;
   logic [7:0] reg_a, reg_b;
   logic       sda_line;
   int         checks = 0;
   int         fails = 0;
   int         done_cnt = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   tws_regport #(.COMMIT_CYCLES(COMMIT)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .addr_sel_i    (addr_sel),
      .wr_prot_i     (wp),
      .port_i        (port),
      .sda_pull_o    (sda_pull),
      .reg_a_o       (reg_a),
      .reg_b_o       (reg_b),
      .commit_busy_o (busy),
      .commit_done_o (done),
      .stop_pulse_o  (stop_p)
   );

   always @(negedge clk) if (rst_n && done) done_cnt++;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; bw();
      scl_m = 1'b1; bw();
      sda_m = 1'b0; bw();
      scl_m = 1'b0; bw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; bw();
      scl_m = 1'b1; bw();
      sda_m = 1'b1; bw();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; bw();
      scl_m = 1'b1; bw(); bw();
      scl_m = 1'b0; bw();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; bw();
      scl_m = 1'b1; bw();
      b = sda_line; bw();
      scl_m = 1'b0; bw();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic get_byte(input logic ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      send_bit(~ack);
   endtask

   task automatic write_reg(input logic [6:0] dev, input logic [7:0] v,
                            output logic a_ack, output logic d_ack);
      bus_start();
      send_byte({dev, 1'b0}, a_ack);
      send_byte(v, d_ack);
      bus_stop();
   endtask

   task automatic wait_commit();
      int n = 0;
      while (busy && n < 2 * COMMIT) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic       a_ack, d_ack;
      logic [7:0] v;
      int         dn;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R11 reset state
      check("R11 reg_a", reg_a, 8'h80);
      check("R11 reg_b", reg_b, 8'h80);
      check("R11 busy", {7'd0, busy}, 8'h00);
      check("R11 sda", {7'd0, sda_pull}, 8'h00);

      // R2 address sweep, select high
      addr_sel = 1'b1;
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({a[6:0], 1'b0}, a_ack);
         bus_stop();
         check("R2 sweep ack", {7'd0, a_ack}, {7'd0, (a == 7'h4E)});
      end
      // R2 select low, general call and both addresses
      addr_sel = 1'b0;
      foreach (v[i]) ;
      for (int k = 0; k < 3; k++) begin
         logic [6:0] ad;
         ad = (k == 0) ? 7'h00 : (k == 1) ? 7'h37 : 7'h4E;
         bus_start();
         send_byte({ad, 1'b0}, a_ack);
         bus_stop();
         check("R2 low-select ack", {7'd0, a_ack}, {7'd0, (ad == 7'h37)});
      end
      addr_sel = 1'b1;
      check("R2 no commit from address-only", {7'd0, busy}, 8'h00);
      check("R1 sda released after stop", {7'd0, sda_pull}, 8'h00);

      // R3 R9 write image A
      dn = done_cnt;
      write_reg(7'h4E, 8'h15, a_ack, d_ack);
      check("R3 data ack", {7'd0, d_ack}, 8'h01);
      repeat (20) @(negedge clk);
      check("R9 busy after stop", {7'd0, busy}, 8'h01);
      check("R9 image A held during commit", reg_a, 8'h80);
      wait_commit();
      check("R3 image A", reg_a, 8'h15);
      check("R4 image B route bits", reg_b, 8'h00);
      check("R9 one done pulse", 8'(done_cnt - dn), 8'h01);

      // R3 R4 write image B
      write_reg(7'h4E, 8'h6A, a_ack, d_ack);
      wait_commit();
      check("R3 image B", reg_b, 8'h6A);
      check("R4 image A route bits", reg_a, 8'h55);

      // R8 write protect
      wp = 1'b1;
      write_reg(7'h4E, 8'h3F, a_ack, d_ack);
      check("R8 protected byte acked", {7'd0, d_ack}, 8'h01);
      repeat (20) @(negedge clk);
      check("R8 no commit", {7'd0, busy}, 8'h00);
      check("R8 image A unchanged", reg_a, 8'h55);
      wp = 1'b0;

      // R3 R4 route-only byte
      write_reg(7'h4E, 8'h9C, a_ack, d_ack);
      wait_commit();
      check("R3 route-only image A", reg_a, 8'h95);
      check("R3 route-only image B", reg_b, 8'hAA);

      // R5 R7 full read with wrap, port changed mid-transfer
      port = 5'h13;
      bus_start();
      send_byte({7'h4E, 1'b1}, a_ack);
      check("R2 read address ack", {7'd0, a_ack}, 8'h01);
      port = 5'h0C;
      get_byte(1'b1, v); check("R5 byte 1 image A", v, 8'h95);
      get_byte(1'b1, v); check("R5 byte 2 image B", v, 8'hAA);
      get_byte(1'b1, v); check("R7 snapshot held from start", v, 8'h13);
      get_byte(1'b0, v); check("R5 wrap to image A", v, 8'h95);
      bus_stop();
      check("R5 sda released after NACK", {7'd0, sda_pull}, 8'h00);

      // R7 new snapshot, low select read
      addr_sel = 1'b0;
      bus_start();
      send_byte({7'h37, 1'b1}, a_ack);
      check("R2 low-select read ack", {7'd0, a_ack}, 8'h01);
      get_byte(1'b1, v);
      get_byte(1'b1, v);
      get_byte(1'b0, v); check("R7 snapshot resampled", v, 8'h0C);
      bus_stop();
      addr_sel = 1'b1;

      // R6 single-byte read
      bus_start();
      send_byte({7'h4E, 1'b1}, a_ack);
      get_byte(1'b0, v); check("R6 first byte", v, 8'h95);
      bus_stop();
      repeat (4) @(negedge clk);
      check("R6 sda released", {7'd0, sda_pull}, 8'h00);
      check("R6 read leaves image A", reg_a, 8'h95);
      check("R6 read leaves image B", reg_b, 8'hAA);
      check("R6 read starts no commit", {7'd0, busy}, 8'h00);

      // R10 write during commit discarded
      dn = done_cnt;
      write_reg(7'h4E, 8'h01, a_ack, d_ack);
      write_reg(7'h4E, 8'h02, a_ack, d_ack);
      check("R10 second byte acked", {7'd0, d_ack}, 8'h01);
      wait_commit();
      repeat (20) @(negedge clk);
      check("R10 image A keeps first", reg_a, 8'h01);
      check("R10 image B", reg_b, 8'h2A);
      check("R10 single commit", 8'(done_cnt - dn), 8'h01);

      // R9 repeated start commits pending write
      bus_start();
      send_byte({7'h4E, 1'b0}, a_ack);
      send_byte(8'h4B, d_ack);
      bus_start();
      send_byte({7'h4E, 1'b1}, a_ack);
      check("R9 busy after repeated start", {7'd0, busy}, 8'h01);
      get_byte(1'b0, v); check("R9 old image during commit", v, 8'h01);
      bus_stop();
      wait_commit();
      check("R9 image B after repeated start", reg_b, 8'h4B);
      check("R4 image A route bits", reg_a, 8'h41);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule